// File: doc/BRIEF.md
# Edge-Latched One-Time-Programmable Memory

This block models an 8192-word by 8-bit one-time-programmable memory whose address is captured by the falling edge of an active-low chip enable rather than held by the requester. Once a word is latched, it is presented on an 8-bit data bus after a fixed number of clock cycles. An active-low output enable gates that bus. The bus is given as a value plus a drive-enable, ready for a pad or an on-chip bus mux. Every cell starts out blank at zero.

A program port can set single bits of the latched word to one. It does this only when the active-low program enable is low and the outputs are disabled. No operation clears a bit. The cell storage is split by output bit into column groups. The upper latched address bits pick a row and the lower bits pick a column inside each group. All timing is counted in clock cycles. A falling chip enable is taken as a new access only when two conditions hold: enough cycles have passed since the previous accepted access, and chip enable has been high for long enough. Any other falling edge is ignored until chip enable goes high and falls again.

Top module: `otp_latched_mem`

## Requirements
- R1: While reset is asserted and just after it is released, `dataOe` and `progErr` are 0. Reset clears the address latch and the output enables. It leaves programmed cells unchanged, so a word programmed before reset reads back the same afterwards.
- R2: The address is latched at the clock edge that first samples `chipEnN` low on an accepted falling edge. Changes on `addr` after that edge have no effect on the word presented until a new accepted falling edge.
- R3: `dataOe` can be 1 only when the edge before sampled both `chipEnN` and `outEnN` low. A change of `outEnN` reaches `dataOe` one cycle later. `chipEnN` sampled high turns `dataOe` off at that edge whatever `outEnN` is. While `dataOe` is 0, `dataOut` is all zeros.
- R4: Every cell reads 0 until it is programmed. Word address bits [12:5] select the row and bits [4:0] select the column. Bit g of `progMask` and `dataOut` belongs to column group g, and programming one word changes no other word.
- R5: With `outEnN` low, `dataOe` rises ACCESS_LAT cycles after the edge that accepted the falling chip enable (default 2) and is 0 before then.
- R6: A `progStrobe` sampled with `progEnN` low, an access active with `chipEnN` low, outputs disabled (`outEnN` low at the previous edge is not the case) and a one-hot `progMask` ORs that bit into the latched word at that edge. A bit that is 1 never returns to 0.
- R7: A `progStrobe` sampled with `progEnN` high, or with a `progMask` that does not have exactly one bit set, changes no cell and makes `progErr` 1 for the following cycle.
- R8: A `progStrobe` sampled while the outputs are enabled or while no access is active changes no cell and does not raise `progErr`.
- R9: A falling chip enable is accepted only if at least CYCLE_MIN (default 4) edges have passed since the previous accepted one and `chipEnN` was sampled high on at least MIN_HIGH (default 2) consecutive edges just before it. A rejected fall starts no access, and `dataOe` stays 0 until a later accepted fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chipEnN | input | 1 | Active-low chip enable; its falling edge latches the address |
| outEnN | input | 1 | Active-low output enable |
| progEnN | input | 1 | Active-low program enable; held high for reads |
| addr | input | 13 | Word address, sampled on an accepted chip-enable fall |
| progStrobe | input | 1 | Request to program one bit of the latched word |
| progMask | input | 8 | One-hot mask choosing the bit to program |
| dataOut | output | 8 | Word presented on the bus, zero when not driven |
| dataOe | output | 1 | Bus drive enable; 0 means high impedance |
| progErr | output | 1 | One-cycle flag for a rejected program strobe |

## Verification
The hardest state to reach is a chip-enable fall that lands at the spacing limit. The bench has to make two kinds of fall that are each one cycle short of legal and show that neither starts an access. In the first, chip enable was held high for only one sample after a long access. In the second, the gap since the previous accepted fall is too short even though chip enable was high long enough. The bench drives these fall patterns cycle by cycle and watches `dataOe` stay low. It then shows that a correctly spaced fall still reads the right word. The cell array is covered by an arithmetic programming pattern followed by a read sweep over all 8192 addresses, so any row or column decode mix-up shows up as a word that differs from the computed value.

// File: rtl/otp_pkg.sv
package otp_pkg;
  // Strobes issued by the control unit to the storage datapath.
  typedef struct packed {
    logic latchAddr;  // capture the address on an accepted chip-enable fall
    logic writeBit;   // OR the one-hot mask into the latched word
  } otp_strobe_t;
endpackage

// File: rtl/otp_ctrl.sv
module otp_ctrl
  import otp_pkg::*;
#(
  parameter int WORD_W     = 8,
  parameter int ACCESS_LAT = 2,
  parameter int CYCLE_MIN  = 4,
  parameter int MIN_HIGH   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEnN,
  input  logic              outEnN,
  input  logic              progEnN,
  input  logic              progStrobe,
  input  logic [WORD_W-1:0] progMask,
  output otp_strobe_t       strobeBus,
  output logic              dataOe,
  output logic              progErr
);
  localparam int LAT_W  = $clog2(ACCESS_LAT + 1);
  localparam int GAP_W  = $clog2(CYCLE_MIN + 1);
  localparam int HIGH_W = $clog2(MIN_HIGH + 1);
  localparam logic [LAT_W-1:0]  LAT_LOAD = LAT_W'(ACCESS_LAT);
  localparam logic [GAP_W-1:0]  GAP_MAX  = GAP_W'(CYCLE_MIN);
  localparam logic [HIGH_W-1:0] HIGH_MAX = HIGH_W'(MIN_HIGH);

  logic              enPrev;
  logic [GAP_W-1:0]  gapCnt;
  logic [HIGH_W-1:0] highCnt;
  logic              active;
  logic [LAT_W-1:0]  latCnt;
  logic              gReg;
  logic              errReg;

  logic fallSeen, gapOk, highOk, acceptFall, maskOk, writeOk, errNext;

  always_comb begin
    fallSeen   = enPrev & ~chipEnN;
    gapOk      = (gapCnt >= GAP_MAX);
    highOk     = (highCnt >= HIGH_MAX);
    acceptFall = fallSeen & gapOk & highOk;
    maskOk     = (progMask != '0) && ((progMask & (progMask - 1'b1)) == '0);
    writeOk    = progStrobe & ~progEnN & maskOk & active & ~chipEnN & gReg;
    errNext    = progStrobe & (progEnN | ~maskOk);
    strobeBus.latchAddr = acceptFall;
    strobeBus.writeBit  = writeOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev  <= 1'b1;
      gapCnt  <= GAP_MAX;
      highCnt <= HIGH_MAX;
      active  <= 1'b0;
      latCnt  <= '0;
      gReg    <= 1'b1;
      errReg  <= 1'b0;
    end else begin
      enPrev <= chipEnN;
      gReg   <= outEnN;
      errReg <= errNext;

      if (chipEnN) begin
        if (highCnt < HIGH_MAX) highCnt <= highCnt + 1'b1;
      end else begin
        highCnt <= '0;
      end

      if (acceptFall) gapCnt <= GAP_W'(1);
      else if (gapCnt < GAP_MAX) gapCnt <= gapCnt + 1'b1;

      if (chipEnN) active <= 1'b0;
      else if (acceptFall) active <= 1'b1;

      if (acceptFall) latCnt <= LAT_LOAD;
      else if (latCnt != '0) latCnt <= latCnt - 1'b1;
    end
  end

  assign dataOe  = active & (latCnt == '0) & ~gReg;
  assign progErr = errReg;
endmodule

// File: rtl/otp_array.sv
module otp_array
  import otp_pkg::*;
#(
  parameter int ROW_BITS = 8,
  parameter int COL_BITS = 5,
  parameter int WORD_W   = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  otp_strobe_t                  strobeBus,
  input  logic [ROW_BITS+COL_BITS-1:0] addr,
  input  logic [WORD_W-1:0]            progMask,
  output logic [WORD_W-1:0]            rdData
);
  localparam int ADDR_W = ROW_BITS + COL_BITS;
  localparam int ROWS   = 1 << ROW_BITS;
  localparam int COLS   = 1 << COL_BITS;

  logic [ADDR_W-1:0]   addrLat;
  logic [ROW_BITS-1:0] rowSel;
  logic [COL_BITS-1:0] colSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrLat <= '0;
    else if (strobeBus.latchAddr) addrLat <= addr;
  end

  assign rowSel = addrLat[ADDR_W-1:COL_BITS];
  assign colSel = addrLat[COL_BITS-1:0];

  // One column group per output bit; each group holds ROWS rows of COLS cells.
  for (genvar g = 0; g < WORD_W; g++) begin : g_group
    logic [COLS-1:0] cellRow [ROWS];

    // Blank state at configuration: every cell reads zero.
    initial begin
      for (int r = 0; r < ROWS; r++) cellRow[r] = '0;
    end

    // Cells only ever move from 0 to 1; reset does not touch them.
    always_ff @(posedge clk) begin
      if (strobeBus.writeBit && progMask[g]) cellRow[rowSel][colSel] <= 1'b1;
    end

    assign rdData[g] = cellRow[rowSel][colSel];
  end
endmodule

// File: rtl/otp_latched_mem.sv
module otp_latched_mem
  import otp_pkg::*;
#(
  parameter int ROW_BITS   = 8,
  parameter int COL_BITS   = 5,
  parameter int WORD_W     = 8,
  parameter int ACCESS_LAT = 2,
  parameter int CYCLE_MIN  = 4,
  parameter int MIN_HIGH   = 2,
  localparam int ADDR_W    = ROW_BITS + COL_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEnN,
  input  logic              outEnN,
  input  logic              progEnN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              progStrobe,
  input  logic [WORD_W-1:0] progMask,
  output logic [WORD_W-1:0] dataOut,
  output logic              dataOe,
  output logic              progErr
);
  otp_strobe_t       strobeBus;
  logic [WORD_W-1:0] rdData;

  otp_ctrl #(
    .WORD_W(WORD_W), .ACCESS_LAT(ACCESS_LAT),
    .CYCLE_MIN(CYCLE_MIN), .MIN_HIGH(MIN_HIGH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .outEnN(outEnN),
    .progEnN(progEnN), .progStrobe(progStrobe), .progMask(progMask),
    .strobeBus(strobeBus), .dataOe(dataOe), .progErr(progErr)
  );

  otp_array #(
    .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .WORD_W(WORD_W)
  ) u_array (
    .clk(clk), .rstN(rstN), .strobeBus(strobeBus), .addr(addr),
    .progMask(progMask), .rdData(rdData)
  );

  // Undriven bus value is held at zero; dataOe is the pad drive enable.
  assign dataOut = dataOe ? rdData : '0;
endmodule

// File: rtl/otp_latched_mem_chk.sv
module otp_latched_mem_chk
  import otp_pkg::*;
#(
  parameter int WORD_W    = 8,
  parameter int CYCLE_MIN = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              chipEnN,
  input logic              outEnN,
  input logic              progEnN,
  input logic              progStrobe,
  input logic [WORD_W-1:0] progMask,
  input logic [WORD_W-1:0] dataOut,
  input logic              dataOe,
  input logic              progErr,
  input otp_strobe_t       strobeBus
);
  localparam int GAP_W = $clog2(CYCLE_MIN + 1);
  logic [GAP_W-1:0] sinceLatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceLatch <= GAP_W'(CYCLE_MIN);
    else if (strobeBus.latchAddr) sinceLatch <= GAP_W'(1);
    else if (sinceLatch < GAP_W'(CYCLE_MIN)) sinceLatch <= sinceLatch + 1'b1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk) !rstN |=> !dataOe && !progErr);

  p_latch_when_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobeBus.latchAddr |-> !chipEnN && !dataOe);

  p_ce_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    chipEnN |=> !dataOe);

  p_oe_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |=> !dataOe);

  p_bus_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> dataOut == '0);

  p_write_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobeBus.writeBit |-> progStrobe && !progEnN && !chipEnN && $countones(progMask) == 1);

  p_ones_stick_r6: assert property (@(posedge clk) disable iff (!rstN)
    dataOe && $past(dataOe) && !$past(strobeBus.latchAddr)
      |-> (dataOut & $past(dataOut)) == $past(dataOut));

  p_err_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    progStrobe && (progEnN || $countones(progMask) != 1) |=> progErr);

  p_no_write_oe_r8: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> !strobeBus.writeBit);

  p_gap_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobeBus.latchAddr |-> sinceLatch >= GAP_W'(CYCLE_MIN));
endmodule

bind otp_latched_mem otp_latched_mem_chk #(.WORD_W(WORD_W), .CYCLE_MIN(CYCLE_MIN)) u_chk (
  .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .outEnN(outEnN), .progEnN(progEnN),
  .progStrobe(progStrobe), .progMask(progMask), .dataOut(dataOut), .dataOe(dataOe),
  .progErr(progErr), .strobeBus(strobeBus)
);

// File: tb/otp_latched_mem_tb.sv
module otp_latched_mem_tb;
  localparam int LAT = 2;
  localparam int NWORDS = 8192;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chipEnN = 1'b1;
  logic        outEnN = 1'b1;
  logic        progEnN = 1'b1;
  logic [12:0] addr = '0;
  logic        progStrobe = 1'b0;
  logic [7:0]  progMask = '0;
  logic [7:0]  dataOut;
  logic        dataOe;
  logic        progErr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  otp_latched_mem u_dut (
    .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .outEnN(outEnN), .progEnN(progEnN),
    .addr(addr), .progStrobe(progStrobe), .progMask(progMask),
    .dataOut(dataOut), .dataOe(dataOe), .progErr(progErr)
  );

  localparam logic [12:0] A1 = 13'h00A5;
  localparam logic [12:0] A2 = 13'h1F00;
  localparam logic [12:0] A3 = 13'h1234;

  function automatic logic [7:0] expWord(input int a);
    logic [7:0] v = 8'h00;
    if (a % 37 == 0) v = 8'h01 << ((a >> 3) % 8);
    if (a == int'(A1)) v = 8'h81;
    if (a == int'(A2)) v = 8'h10;
    if (a == int'(A3)) v = 8'h04;
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doRead(input logic [12:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk); addr = a; chipEnN = 0; outEnN = 0;
    repeat (LAT + 1) @(posedge clk);
    @(negedge clk); d = dataOut; oe = dataOe;
    chipEnN = 1; outEnN = 1;
    repeat (2) @(posedge clk);
  endtask

  task automatic doProg(input logic [12:0] a, input logic [7:0] m, input logic pHigh,
                        output logic err);
    @(negedge clk); addr = a; chipEnN = 0; outEnN = 1; progEnN = pHigh;
    @(posedge clk);
    @(negedge clk); progStrobe = 1; progMask = m;
    @(posedge clk);
    @(negedge clk); progStrobe = 0; progMask = '0; err = progErr;
    chipEnN = 1; progEnN = 1;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic oe, err;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset dataOe", dataOe, 0);
    check("R1 reset progErr", progErr, 0);
    rstN = 1;
    @(negedge clk);
    check("R1 after release dataOe", dataOe, 0);

    // Blank read before any programming (R4)
    doRead(A1, d, oe);
    check("R4 blank oe", oe, 1);
    check("R4 blank word", d, 8'h00);

    // Programming (R6, R7)
    doProg(A1, 8'h01, 0, err); check("R6 no error", err, 0);
    doProg(A1, 8'h80, 0, err); check("R6 no error", err, 0);
    doProg(A1, 8'h01, 0, err); check("R6 reprogram no error", err, 0);
    doRead(A1, d, oe);         check("R6 bits OR together", d, 8'h81);
    doProg(A2, 8'h10, 0, err); check("R6 no error", err, 0);
    doProg(A2, 8'h01, 1, err); check("R7 P high flags error", err, 1);
    doProg(A2, 8'h03, 0, err); check("R7 two-bit mask flags error", err, 1);
    doProg(A2, 8'h00, 0, err); check("R7 empty mask flags error", err, 1);
    doProg(A3, 8'h04, 0, err); check("R6 no error", err, 0);
    doRead(A2, d, oe);         check("R7 ignored strobes leave word", d, 8'h10);

    // R8: strobe with outputs enabled
    @(negedge clk); addr = A2; chipEnN = 0; outEnN = 0; progEnN = 0;
    @(posedge clk);
    @(negedge clk); progStrobe = 1; progMask = 8'h02;
    @(posedge clk);
    @(negedge clk); progStrobe = 0; progMask = '0;
    check("R8 oe-enabled strobe no error", progErr, 0);
    progEnN = 1; chipEnN = 1; outEnN = 1;
    repeat (2) @(posedge clk);
    // R8: strobe with no active access
    @(negedge clk); progEnN = 0; progStrobe = 1; progMask = 8'h02;
    @(posedge clk);
    @(negedge clk); progStrobe = 0; progMask = '0; progEnN = 1;
    check("R8 idle strobe no error", progErr, 0);
    doRead(A2, d, oe); check("R8 word unchanged", d, 8'h10);

    // R5 latency, R2 latch, R3 enables
    repeat (4) @(posedge clk);
    @(negedge clk); addr = A1; chipEnN = 0; outEnN = 0;
    @(posedge clk); @(negedge clk);
    check("R5 not valid at +0", dataOe, 0);
    addr = A3;
    @(posedge clk); @(negedge clk);
    check("R5 not valid at +1", dataOe, 0);
    @(posedge clk); @(negedge clk);
    check("R5 valid at +2", dataOe, 1);
    check("R2 latched word kept", dataOut, 8'h81);
    addr = A2;
    repeat (2) @(posedge clk); @(negedge clk);
    check("R2 address change ignored", dataOut, 8'h81);
    outEnN = 1;
    @(posedge clk); @(negedge clk);
    check("R3 G high disables", dataOe, 0);
    check("R3 bus zero when off", dataOut, 8'h00);
    outEnN = 0;
    @(posedge clk); @(negedge clk);
    check("R3 G low enables", dataOe, 1);
    chipEnN = 1;
    @(posedge clk); @(negedge clk);
    check("R3 E high disables", dataOe, 0);
    repeat (4) @(posedge clk);

    // R9: short high time after a long access
    @(negedge clk); addr = A1; chipEnN = 0; outEnN = 0;
    repeat (5) @(posedge clk);
    @(negedge clk); chipEnN = 1;
    @(posedge clk);
    @(negedge clk); chipEnN = 0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); @(negedge clk);
      check("R9 short high rejected", dataOe, 0);
    end
    chipEnN = 1;
    repeat (2) @(posedge clk);
    @(negedge clk); addr = A3; chipEnN = 0;
    @(posedge clk);
    @(negedge clk); chipEnN = 1;          // accepted fall, then too-soon refall
    repeat (2) @(posedge clk);
    @(negedge clk); addr = A1; chipEnN = 0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); @(negedge clk);
      check("R9 short gap rejected", dataOe, 0);
    end
    chipEnN = 1; outEnN = 1;
    repeat (2) @(posedge clk);
    doRead(A3, d, oe);
    check("R9 legal access oe", oe, 1);
    check("R9 legal access word", d, 8'h04);

    // R1: cells survive reset
    @(negedge clk); rstN = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 in reset dataOe", dataOe, 0);
    rstN = 1;
    doRead(A1, d, oe);
    check("R1 cells kept over reset", d, 8'h81);

    // Pattern programming, then full sweep (R4, R6)
    for (int a = 0; a < NWORDS; a += 37) begin
      doProg(13'(a), 8'h01 << ((a >> 3) % 8), 0, err);
      check("R6 pattern program no error", err, 0);
    end
    for (int a = 0; a < NWORDS; a++) begin
      doRead(13'(a), d, oe);
      check("R4 sweep oe", oe, 1);
      check("R4 sweep word", d, expWord(a));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule